// File: doc/BRIEF.md
# Exception Entry Controller

This block computes the architectural state a processor core takes on when it accepts an exception. The pipeline presents a single-cycle request together with an exception kind, a cause code, the PC of the interrupted instruction, a flag that says whether that instruction sits in a branch delay slot, the current Status and Cause values and a user-mode bit. On the clock edge that samples the request, the block registers the new fetch PC, the return address in the register that belongs to the exception's class, the updated Status and Cause values and the translation-related registers that a hard reset initialises.

Exceptions fall into three classes, and each class has its own return register and vector. Hard reset, soft reset and non-maskable interrupt form the error class. They save into the error return register and enter at the boot vector. A debug exception saves into the debug return register and enters at the debug vector. TLB refill, machine check and every other exception form the general class. They save into the exception return register and enter at a base chosen by the boot-exception-vector Status bit, plus an offset. The block also decides, combinationally, whether a coprocessor-0 access may proceed.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `pc_o` is 0xBFC00000, `status_o` is 0x00400004 (bit 22 boot-vector select, bit 2 error level), `random_o` is TLB_ENTRIES-1, and every other state output is zero.
- R2: A hard-reset request (kind 0) loads `status_o` with 0x00400004 only (bit 28, the coprocessor-0 usable bit, is clear). It also zeroes `wired_o` and `watchlo_o`, sets `random_o` to TLB_ENTRIES-1, clears `debug_mode_o`, saves the return address in `errorepc_o` and sets `pc_o` to 0xBFC00000.
- R3: A soft-reset request (kind 1) loads `status_o` with 0x00500004 (bit 20 soft-reset flag, plus boot-vector select and error level), zeroes `watchlo_o`, saves the return address in `errorepc_o` and sets `pc_o` to 0xBFC00000.
- R4: An NMI request (kind 2) loads `status_o` with 0x00480004 (bit 19 NMI flag, plus boot-vector select and error level), saves the return address in `errorepc_o` and sets `pc_o` to 0xBFC00000.
- R5: For every valid kind, the saved return address is `pc_i`-4 when `in_slot_i` is 1 and `pc_i` otherwise. `slot_clr_o` is 1 for exactly the cycle after a request with `in_slot_i` set.
- R6: A general-class request (kinds 4, 5, 6) saves the return address in `epc_o`. It sets `status_o` to `status_i` with bit 1 (exception level) set. `cause_o` equals `cause_i` with bit 31 set to `in_slot_i` and bits 6:2 replaced by the exception code.
- R7: The general vector is 0xBFC00200 when `status_i` bit 22 is 1 and 0x80000000 when it is 0. The offset added is 0x000 for TLB refill (kind 4) and 0x180 for kinds 5 and 6.
- R8: A machine-check request (kind 6) writes code 24 into Cause bits 6:2, whatever `code_i` holds.
- R9: A debug request (kind 3) saves the return address in `depc_o`, sets `debug_mode_o`, sets `pc_o` to 0xBFC00480, and leaves `status_o`, `cause_o` and `epc_o` unchanged.
- R10: `cp0_ok_o` is 0 only when `user_mode_i` is 1 and `status_i` bits 28, 2 and 1 are all 0. In every other case it is 1.
- R11: A request with kind 7 sets `bad_kind_o` for one cycle and leaves every other registered output unchanged.
- R12: In a cycle without a request, the registered outputs keep their values, and `slot_clr_o` and `bad_kind_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle exception request |
| kind_i | input | 3 | Exception kind (0 hard reset, 1 soft reset, 2 NMI, 3 debug, 4 TLB refill, 5 other general, 6 machine check, 7 invalid) |
| code_i | input | 5 | Exception code for general kinds |
| pc_i | input | 32 | PC of the interrupted instruction |
| in_slot_i | input | 1 | Interrupted instruction is in a branch delay slot |
| user_mode_i | input | 1 | Core runs in user mode |
| status_i | input | 32 | Current Status value |
| cause_i | input | 32 | Current Cause value |
| pc_o | output | 32 | New fetch PC |
| epc_o | output | 32 | General exception return address |
| errorepc_o | output | 32 | Error-class return address |
| depc_o | output | 32 | Debug return address |
| status_o | output | 32 | Status value after entry |
| cause_o | output | 32 | Cause value after entry |
| wired_o | output | RW | Wired register |
| watchlo_o | output | 32 | WatchLo register |
| random_o | output | RW | Random register |
| slot_clr_o | output | 1 | Pulse: clear the pipeline's delay-slot flag |
| debug_mode_o | output | 1 | Debug-mode flag |
| bad_kind_o | output | 1 | Pulse: invalid exception kind was requested |
| cp0_ok_o | output | 1 | Coprocessor-0 access permitted |

## Verification
The assertions assume that `req_i` and `kind_i` are defined whenever reset is released. They also assume that `status_i` and `cause_i` are steady during a request cycle. The consequence checks compare outputs one cycle later against the inputs sampled with the request. The bench drives every input on the falling edge, holds each request for exactly one cycle, and drops it before the next rising edge. The error-class Status checks assume the hard-reset values do not depend on `status_i`, so the bench deliberately gives those rows nonzero Status inputs to test that.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        EK_HARD   = 3'd0,
        EK_SOFT   = 3'd1,
        EK_NMI    = 3'd2,
        EK_DEBUG  = 3'd3,
        EK_REFILL = 3'd4,
        EK_GEN    = 3'd5,
        EK_MCHK   = 3'd6,
        EK_BAD    = 3'd7
    } exc_kind_e;

    typedef enum logic [1:0] {
        VC_ERROR   = 2'd0,
        VC_DEBUG   = 2'd1,
        VC_GENERAL = 2'd2,
        VC_NONE    = 2'd3
    } vec_class_e;

    localparam int ST_CU0 = 28;
    localparam int ST_BEV = 22;
    localparam int ST_SR  = 20;
    localparam int ST_NMI = 19;
    localparam int ST_ERL = 2;
    localparam int ST_EXL = 1;
    localparam int CA_BD  = 31;
    localparam int CA_CODE_LO = 2;
    localparam int CA_CODE_HI = 6;

    localparam logic [4:0] MCHK_CODE = 5'd24;

endpackage

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
    parameter int XLEN      = 32,
    parameter int INSN_SIZE = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            in_slot_i,
    output logic [XLEN-1:0] ret_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_SIZE);

    always_comb begin
        ret_o = in_slot_i ? (pc_i - STEP) : pc_i;
    end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] DEBUG_VEC  = 32'hBFC0_0480,
    parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] NORM_BASE  = 32'h8000_0000,
    parameter logic [XLEN-1:0] REFILL_OFF = 32'h0000_0000,
    parameter logic [XLEN-1:0] OTHER_OFF  = 32'h0000_0180
) (
    input  logic [2:0]      kind_i,
    input  logic            bev_i,
    output vec_class_e      cls_o,
    output logic [XLEN-1:0] vec_o
);
    logic [XLEN-1:0] base;

    always_comb begin
        base = bev_i ? BOOT_BASE : NORM_BASE;
        unique case (exc_kind_e'(kind_i))
            EK_HARD, EK_SOFT, EK_NMI: begin cls_o = VC_ERROR;   vec_o = RESET_VEC;          end
            EK_DEBUG:                 begin cls_o = VC_DEBUG;   vec_o = DEBUG_VEC;          end
            EK_REFILL:                begin cls_o = VC_GENERAL; vec_o = base + REFILL_OFF;  end
            EK_GEN, EK_MCHK:          begin cls_o = VC_GENERAL; vec_o = base + OTHER_OFF;   end
            default:                  begin cls_o = VC_NONE;    vec_o = RESET_VEC;          end
        endcase
    end
endmodule

// File: rtl/exc_cp0_gate.sv
module exc_cp0_gate (
    input  logic user_mode_i,
    input  logic cu0_i,
    input  logic erl_i,
    input  logic exl_i,
    output logic ok_o
);
    always_comb begin
        ok_o = !(user_mode_i && !cu0_i && !erl_i && !exl_i);
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int TLB_ENTRIES = 16,
    parameter int RW          = $clog2(TLB_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [2:0]    kind_i,
    input  logic [4:0]    code_i,
    input  logic [31:0]   pc_i,
    input  logic          in_slot_i,
    input  logic          user_mode_i,
    input  logic [31:0]   status_i,
    input  logic [31:0]   cause_i,
    output logic [31:0]   pc_o,
    output logic [31:0]   epc_o,
    output logic [31:0]   errorepc_o,
    output logic [31:0]   depc_o,
    output logic [31:0]   status_o,
    output logic [31:0]   cause_o,
    output logic [RW-1:0] wired_o,
    output logic [31:0]   watchlo_o,
    output logic [RW-1:0] random_o,
    output logic          slot_clr_o,
    output logic          debug_mode_o,
    output logic          bad_kind_o,
    output logic          cp0_ok_o
);
    localparam logic [31:0] RESET_VEC = 32'hBFC0_0000;
    localparam logic [31:0] ST_BOOT   = (32'd1 << ST_BEV) | (32'd1 << ST_ERL);
    localparam logic [RW-1:0] RAND_TOP = RW'(TLB_ENTRIES - 1);

    typedef struct packed {
        logic [31:0]   pc;
        logic [31:0]   epc;
        logic [31:0]   errorepc;
        logic [31:0]   depc;
        logic [31:0]   status;
        logic [31:0]   cause;
        logic [RW-1:0] wired;
        logic [31:0]   watchlo;
        logic [RW-1:0] random;
        logic          slot_clr;
        logic          dm;
        logic          bad;
    } entry_state_t;

    localparam entry_state_t RESET_STATE = '{
        pc: RESET_VEC, epc: '0, errorepc: '0, depc: '0, status: ST_BOOT,
        cause: '0, wired: '0, watchlo: '0, random: RAND_TOP,
        slot_clr: 1'b0, dm: 1'b0, bad: 1'b0
    };

    entry_state_t st_d, st_q;
    logic [31:0]  ret_addr;
    logic [31:0]  vec_addr;
    vec_class_e   vec_cls;
    logic [4:0]   code_eff;

    exc_ret_addr #(.XLEN(32), .INSN_SIZE(4)) u_ret (
        .pc_i      (pc_i),
        .in_slot_i (in_slot_i),
        .ret_o     (ret_addr)
    );

    exc_vec_sel #(.XLEN(32), .RESET_VEC(RESET_VEC)) u_vec (
        .kind_i (kind_i),
        .bev_i  (status_i[ST_BEV]),
        .cls_o  (vec_cls),
        .vec_o  (vec_addr)
    );

    exc_cp0_gate u_gate (
        .user_mode_i (user_mode_i),
        .cu0_i       (status_i[ST_CU0]),
        .erl_i       (status_i[ST_ERL]),
        .exl_i       (status_i[ST_EXL]),
        .ok_o        (cp0_ok_o)
    );

    always_comb begin
        st_d          = st_q;
        st_d.slot_clr = 1'b0;
        st_d.bad      = 1'b0;
        code_eff      = (exc_kind_e'(kind_i) == EK_MCHK) ? MCHK_CODE : code_i;
        if (req_i) begin
            if (vec_cls == VC_NONE) begin
                st_d.bad = 1'b1;
            end else begin
                st_d.pc       = vec_addr;
                st_d.slot_clr = in_slot_i;
                unique case (vec_cls)
                    VC_ERROR: begin
                        st_d.errorepc = ret_addr;
                        st_d.status   = ST_BOOT;
                        unique case (exc_kind_e'(kind_i))
                            EK_HARD: begin
                                st_d.wired   = '0;
                                st_d.watchlo = '0;
                                st_d.random  = RAND_TOP;
                                st_d.dm      = 1'b0;
                            end
                            EK_SOFT: begin
                                st_d.status[ST_SR] = 1'b1;
                                st_d.watchlo       = '0;
                            end
                            default: st_d.status[ST_NMI] = 1'b1;
                        endcase
                    end
                    VC_DEBUG: begin
                        st_d.depc = ret_addr;
                        st_d.dm   = 1'b1;
                    end
                    default: begin
                        st_d.epc                         = ret_addr;
                        st_d.status                      = status_i;
                        st_d.status[ST_EXL]              = 1'b1;
                        st_d.cause                       = cause_i;
                        st_d.cause[CA_BD]                = in_slot_i;
                        st_d.cause[CA_CODE_HI:CA_CODE_LO] = code_eff;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign pc_o         = st_q.pc;
    assign epc_o        = st_q.epc;
    assign errorepc_o   = st_q.errorepc;
    assign depc_o       = st_q.depc;
    assign status_o     = st_q.status;
    assign cause_o      = st_q.cause;
    assign wired_o      = st_q.wired;
    assign watchlo_o    = st_q.watchlo;
    assign random_o     = st_q.random;
    assign slot_clr_o   = st_q.slot_clr;
    assign debug_mode_o = st_q.dm;
    assign bad_kind_o   = st_q.bad;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic [2:0]  kind_i,
    input logic        in_slot_i,
    input logic        user_mode_i,
    input logic [31:0] status_i,
    input logic [31:0] pc_o,
    input logic [31:0] status_o,
    input logic [31:0] cause_o,
    input logic [31:0] epc_o,
    input logic        slot_clr_o,
    input logic        debug_mode_o,
    input logic        bad_kind_o,
    input logic        cp0_ok_o
);
    AST_HARD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd0) |=> (status_o == 32'h0040_0004 && pc_o == 32'hBFC0_0000)); // R2

    AST_SLOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i != 3'd7 && in_slot_i) |=> slot_clr_o); // R5

    AST_GEN_EXL_BD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i >= 3'd4 && kind_i <= 3'd6) |=> (status_o[1] && cause_o[31] == $past(in_slot_i))); // R6

    AST_DEBUG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd3) |=> (debug_mode_o && pc_o == 32'hBFC0_0480 && $stable(epc_o) && $stable(status_o))); // R9

    AST_CP0_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        !cp0_ok_o |-> (user_mode_i && !status_i[28] && !status_i[2] && !status_i[1])); // R10

    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && kind_i == 3'd7) |=> (bad_kind_o && $stable(pc_o) && $stable(status_o) && $stable(cause_o))); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(pc_o) && $stable(status_o) && !slot_clr_o && !bad_kind_o)); // R12
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .kind_i       (kind_i),
    .in_slot_i    (in_slot_i),
    .user_mode_i  (user_mode_i),
    .status_i     (status_i),
    .pc_o         (pc_o),
    .status_o     (status_o),
    .cause_o      (cause_o),
    .epc_o        (epc_o),
    .slot_clr_o   (slot_clr_o),
    .debug_mode_o (debug_mode_o),
    .bad_kind_o   (bad_kind_o),
    .cp0_ok_o     (cp0_ok_o)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
    localparam int  TLB_N = 16;
    localparam int  RW    = $clog2(TLB_N);
    localparam time TCLK  = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [2:0]    kind_i = '0;
    logic [4:0]    code_i = '0;
    logic [31:0]   pc_i = '0;
    logic          in_slot_i = 1'b0;
    logic          user_mode_i = 1'b0;
    logic [31:0]   status_i = '0;
    logic [31:0]   cause_i = '0;
    logic [31:0]   pc_o, epc_o, errorepc_o, depc_o, status_o, cause_o, watchlo_o;
    logic [RW-1:0] wired_o, random_o;
    logic          slot_clr_o, debug_mode_o, bad_kind_o, cp0_ok_o;

    int checks = 0;
    int failures = 0;

    always #(TCLK/2) clk = ~clk;

    exc_entry_ctrl #(.TLB_ENTRIES(TLB_N)) u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .code_i(code_i),
        .pc_i(pc_i), .in_slot_i(in_slot_i), .user_mode_i(user_mode_i),
        .status_i(status_i), .cause_i(cause_i), .pc_o(pc_o), .epc_o(epc_o),
        .errorepc_o(errorepc_o), .depc_o(depc_o), .status_o(status_o),
        .cause_o(cause_o), .wired_o(wired_o), .watchlo_o(watchlo_o),
        .random_o(random_o), .slot_clr_o(slot_clr_o), .debug_mode_o(debug_mode_o),
        .bad_kind_o(bad_kind_o), .cp0_ok_o(cp0_ok_o)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [4:0]  code;
        logic [31:0] pc;
        logic        slot;
        logic [31:0] st;
        logic [31:0] ca;
        logic [31:0] e_pc;
        logic [31:0] e_ret;
        logic [31:0] e_st;
        logic [31:0] e_ca;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 5'd0, 32'h0000_1000, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'hBFC0_0000, 32'h0000_1000, 32'h0040_0004, 32'h0},
        '{3'd1, 5'd0, 32'h0000_2004, 1'b1, 32'h1000_0000, 32'h0, 32'hBFC0_0000, 32'h0000_2000, 32'h0050_0004, 32'h0},
        '{3'd2, 5'd0, 32'h0000_3000, 1'b0, 32'h0000_0000, 32'h0, 32'hBFC0_0000, 32'h0000_3000, 32'h0048_0004, 32'h0},
        '{3'd3, 5'd0, 32'h0000_4008, 1'b1, 32'h0000_0000, 32'h0, 32'hBFC0_0480, 32'h0000_4004, 32'h0048_0004, 32'h0},
        '{3'd4, 5'd2, 32'h0000_5000, 1'b0, 32'h0040_0000, 32'h0000_FF00, 32'hBFC0_0200, 32'h0000_5000, 32'h0040_0002, 32'h0000_FF08},
        '{3'd5, 5'd8, 32'h0000_6004, 1'b1, 32'h0000_0010, 32'h0000_007C, 32'h8000_0180, 32'h0000_6000, 32'h0000_0012, 32'h8000_0020},
        '{3'd6, 5'd3, 32'h0000_7000, 1'b0, 32'h0000_0000, 32'h8000_0300, 32'h8000_0180, 32'h0000_7000, 32'h0000_0002, 32'h0000_0360},
        '{3'd4, 5'd3, 32'h0000_8000, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_8000, 32'h0000_0002, 32'h0000_000C}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] k, input logic [4:0] c, input logic [31:0] p,
                          input logic s, input logic [31:0] st, input logic [31:0] ca);
        @(negedge clk);
        req_i = 1'b1; kind_i = k; code_i = c; pc_i = p; in_slot_i = s;
        status_i = st; cause_i = ca;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic cp0_case(input logic um, input logic [31:0] st, input logic exp, input string tag);
        user_mode_i = um; status_i = st;
        #1;
        chk(tag, {31'd0, cp0_ok_o}, {31'd0, exp});
    endtask

    initial begin
        #(TCLK * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] keep_pc, keep_st, keep_epc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pc", pc_o, 32'hBFC0_0000);
        chk("R1 status", status_o, 32'h0040_0004);
        chk("R1 random", {28'd0, random_o}, TLB_N - 1);
        chk("R1 epc", epc_o, 32'h0);
        chk("R1 dm", {31'd0, debug_mode_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after release", pc_o, 32'hBFC0_0000);

        for (int i = 0; i < NV; i++) begin
            do_req(TBL[i].kind, TBL[i].code, TBL[i].pc, TBL[i].slot, TBL[i].st, TBL[i].ca);
            // R7 vector, R2/R3/R4/R9 entry, R5 return address and slot pulse
            chk($sformatf("R7 pc row%0d", i), pc_o, TBL[i].e_pc);
            chk($sformatf("R5 slot_clr row%0d", i), {31'd0, slot_clr_o}, {31'd0, TBL[i].slot});
            chk($sformatf("R2 R3 R4 R6 status row%0d", i), status_o, TBL[i].e_st);
            if (TBL[i].kind <= 3'd2)
                chk($sformatf("R5 errorepc row%0d", i), errorepc_o, TBL[i].e_ret);
            else if (TBL[i].kind == 3'd3) begin
                chk($sformatf("R9 depc row%0d", i), depc_o, TBL[i].e_ret);
                chk("R9 dm set", {31'd0, debug_mode_o}, 32'd1);
                chk("R9 epc unchanged", epc_o, 32'h0);
            end else begin
                chk($sformatf("R6 epc row%0d", i), epc_o, TBL[i].e_ret);
                chk($sformatf("R6 R8 cause row%0d", i), cause_o, TBL[i].e_ca);
            end
            if (TBL[i].kind == 3'd1 || TBL[i].kind == 3'd0)
                chk("R3 watchlo", watchlo_o, 32'h0);
        end

        chk("R9 dm survives general", {31'd0, debug_mode_o}, 32'd1);

        // R11: invalid kind
        keep_pc = pc_o; keep_st = status_o; keep_epc = epc_o;
        do_req(3'd7, 5'd9, 32'h0000_9004, 1'b1, 32'h0040_0000, 32'hFFFF_FFFF);
        chk("R11 bad pulse", {31'd0, bad_kind_o}, 32'd1);
        chk("R11 pc held", pc_o, keep_pc);
        chk("R11 status held", status_o, keep_st);
        chk("R11 epc held", epc_o, keep_epc);
        chk("R11 no slot pulse", {31'd0, slot_clr_o}, 32'd0);

        // R12: idle cycle
        @(negedge clk);
        chk("R12 bad cleared", {31'd0, bad_kind_o}, 32'd0);
        chk("R12 pc held", pc_o, keep_pc);

        // R2: hard reset request clears debug mode and reloads random
        do_req(3'd0, 5'd0, 32'h0000_A008, 1'b1, 32'hFFFF_FFFF, 32'h0);
        chk("R2 dm cleared", {31'd0, debug_mode_o}, 32'd0);
        chk("R2 random", {28'd0, random_o}, TLB_N - 1);
        chk("R2 wired", {28'd0, wired_o}, 32'd0);
        chk("R2 watchlo", watchlo_o, 32'd0);
        chk("R2 errorepc slot", errorepc_o, 32'h0000_A004);
        chk("R2 status no cu0", status_o, 32'h0040_0004);
        @(negedge clk);
        chk("R5 slot pulse one cycle", {31'd0, slot_clr_o}, 32'd0);

        // R10: coprocessor-0 permission
        cp0_case(1'b1, 32'h0000_0000, 1'b0, "R10 user all clear");
        cp0_case(1'b1, 32'h1000_0000, 1'b1, "R10 user cu0");
        cp0_case(1'b1, 32'h0000_0002, 1'b1, "R10 user exl");
        cp0_case(1'b1, 32'h0000_0004, 1'b1, "R10 user erl");
        cp0_case(1'b0, 32'h0000_0000, 1'b1, "R10 kernel");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule